// File: doc/BRIEF.md
# 3x3 Image Convolution Datapath

This block filters a pixel stream with a programmable 3x3 kernel. Each clock it can take three 8-bit pixels, one from each of three vertically adjacent image lines in raster order. It shifts them into a 3x3 window, multiplies the nine window pixels by nine 8-bit coefficients and sums the products into one 20-bit result. The line buffers that feed the three row buses are outside the block. So is any padding at image edges.

A mode input reuses the same nine multipliers as a 9-tap FIR filter, which takes its samples from the first row bus only. Another input selects whether pixels and coefficients are two's complement or unsigned. The nine coefficients come from a separate register block as one flat bus. A frame pulse empties the window and the pipeline between images.

Top module: `conv3_filter`

## Requirements
- R1: The result is the sum over k = 0..8 of coef[k]·P[k+1]. Coefficient k sits at `coef_bus[8k+7:8k]`, so k = 0 is the top-left kernel weight. Coefficients are used one clock after their pixels enter the window and must be held steady while samples are in flight.
- R2: In 2-D mode (`mode_1d` = 0), `row0_px` feeds window positions P1..P3, `row1_px` feeds P4..P6 and `row2_px` feeds P7..P9. Within each row, P1/P4/P7 hold the oldest accepted column and P3/P6/P9 the newest.
- R3: In 1-D mode (`mode_1d` = 1), the window is one delay line fed from `row0_px`. P1 holds the oldest of the last nine accepted samples and P9 the newest. `row1_px` and `row2_px` have no effect on the result.
- R4: `signed_mode` = 1 treats pixels and coefficients as two's complement. `signed_mode` = 0 treats them as unsigned. The setting is captured together with each accepted pixel column.
- R5: The 20-bit output never overflows. In unsigned mode the result stays at or below 585225. In signed mode it stays within -146304..147456, as a two's complement 20-bit value.
- R6: A column sampled with `in_valid` = 1 at rising edge n produces `out_valid` = 1 and its `out_data` after edge n+2. `out_valid` is 0 in every other cycle.
- R7: A cycle with `in_valid` = 0 leaves the window unchanged. It produces an `out_valid` = 0 slot two edges later.
- R8: `frame_start` = 1 at an edge clears every window position to zero and clears all pipeline valid bits, even if `in_valid` is also 1. No `out_valid` follows from that edge.
- R9: While `rst` is high and after it is released, `out_valid` and `out_data` are zero until the first accepted column has passed through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Clears window and pipeline |
| mode_1d | input | 1 | 0 = 3x3 window, 1 = 9-tap FIR on row 0 |
| signed_mode | input | 1 | 1 = two's complement, 0 = unsigned |
| in_valid | input | 1 | Row buses carry a new column |
| row0_px | input | 8 | Pixel of the top line (FIR sample in 1-D mode) |
| row1_px | input | 8 | Pixel of the middle line |
| row2_px | input | 8 | Pixel of the bottom line |
| coef_bus | input | 72 | Nine 8-bit coefficients, index k at bits 8k+7:8k |
| out_data | output | 20 | Registered sum of products |
| out_valid | output | 1 | out_data holds a result |

## Verification
On every cycle, the embedded properties check four things. A valid output only appears three samples after an accepted column. A frame pulse kills the next output. The window holds while input is idle. Every valid sum lies inside the signed or unsigned range of its arithmetic mode. The numeric correctness of the sums can only be shown by the bench's scenarios, which compare every cycle against an independent model. That covers the row-to-position mapping in 2-D mode, the single delay line of 1-D mode and the indifference to the upper row buses in that mode. It also covers sign handling at the extreme operand values and the effect of idle cycles and a mid-stream frame pulse.

// File: rtl/conv3_pkg.sv
package conv3_pkg;

    localparam int PIX_W   = 8;
    localparam int COEF_W  = 8;
    localparam int ROWS    = 3;
    localparam int COLS    = 3;
    localparam int TAPS    = ROWS * COLS;
    localparam int PROD_W  = PIX_W + COEF_W;
    localparam int ACC_W   = 20;
    localparam int EXT_W   = ACC_W - PROD_W;

    // extreme sums, used by range checks
    localparam int UMAX_SUM = TAPS * ((2 ** PIX_W) - 1) * ((2 ** COEF_W) - 1);
    localparam int SMAX_SUM = TAPS * (2 ** (PIX_W - 1)) * (2 ** (COEF_W - 1));
    localparam int SMIN_SUM = -(TAPS * (2 ** (PIX_W - 1)) * ((2 ** (COEF_W - 1)) - 1));

    typedef logic [PIX_W-1:0]  pix_t;
    typedef logic [COEF_W-1:0] coef_t;
    typedef logic [ACC_W-1:0]  acc_t;

    typedef enum logic {ARITH_UNSIGNED = 1'b0, ARITH_SIGNED = 1'b1} arith_e;
    typedef enum logic {SHAPE_2D = 1'b0, SHAPE_1D = 1'b1} shape_e;

    typedef struct packed {
        logic   vld;
        arith_e arith;
    } stage_tag_t;

    // one product, widened to accumulator width per arithmetic mode
    function automatic acc_t mul_ext(input pix_t p, input coef_t c, input arith_e a);
        logic signed [PROD_W-1:0] sp;
        logic        [PROD_W-1:0] up;
        sp = $signed(p) * $signed(c);
        up = p * c;
        if (a == ARITH_SIGNED)
            return {{EXT_W{sp[PROD_W-1]}}, sp};
        else
            return {{EXT_W{1'b0}}, up};
    endfunction

endpackage

// File: rtl/conv3_window.sv
module conv3_window
    import conv3_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  frame_clr,
    input  logic                  in_valid,
    input  shape_e                shape,
    input  arith_e                arith_in,
    input  pix_t [ROWS-1:0]       rows_in,
    output pix_t [TAPS-1:0]       win_q,
    output stage_tag_t            tag_q
);

    pix_t [TAPS-1:0] win_nxt;

    // Position k holds P(k+1). The last column of each row takes the row bus in 2-D mode;
    // in 1-D mode the rows chain into one line fed by row 0.
    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        if (k == TAPS - 1) begin : g_head
            assign win_nxt[k] = (shape == SHAPE_1D) ? rows_in[0] : rows_in[ROWS-1];
        end else if ((k % COLS) == COLS - 1) begin : g_rowend
            assign win_nxt[k] = (shape == SHAPE_1D) ? win_q[k+1] : rows_in[k / COLS];
        end else begin : g_inner
            assign win_nxt[k] = win_q[k+1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q     <= '0;
            tag_q.vld   <= 1'b0;
            tag_q.arith <= ARITH_UNSIGNED;
        end else if (frame_clr) begin
            win_q     <= '0;
            tag_q.vld <= 1'b0;
        end else begin
            tag_q.vld <= in_valid;
            if (in_valid) begin
                win_q       <= win_nxt;
                tag_q.arith <= arith_in;
            end
        end
    end

    // R7
    window_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !frame_clr) |=> $stable(win_q));

    // R8
    window_clear_chk: assert property (@(posedge clk) disable iff (rst)
        frame_clr |=> (win_q == '0 && !tag_q.vld));

endmodule

// File: rtl/conv3_mac.sv
module conv3_mac
    import conv3_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  frame_clr,
    input  pix_t  [TAPS-1:0]      win,
    input  coef_t [TAPS-1:0]      coef,
    input  stage_tag_t            tag_in,
    output acc_t                  acc_q,
    output logic                  vld_q
);

    acc_t [TAPS-1:0] prod_q;
    stage_tag_t      tag_p;
    arith_e          acc_arith_q;
    acc_t            sum_d;

    // multiply stage
    always_ff @(posedge clk) begin
        if (rst || frame_clr) begin
            prod_q      <= '0;
            tag_p.vld   <= 1'b0;
            tag_p.arith <= ARITH_UNSIGNED;
        end else begin
            for (int k = 0; k < TAPS; k++)
                prod_q[k] <= mul_ext(win[k], coef[k], tag_in.arith);
            tag_p <= tag_in;
        end
    end

    always_comb begin
        acc_t s;
        s = '0;
        for (int k = 0; k < TAPS; k++)
            s = s + prod_q[k];
        sum_d = s;
    end

    // sum stage
    always_ff @(posedge clk) begin
        if (rst || frame_clr) begin
            acc_q       <= '0;
            vld_q       <= 1'b0;
            acc_arith_q <= ARITH_UNSIGNED;
        end else begin
            acc_q       <= sum_d;
            vld_q       <= tag_p.vld;
            acc_arith_q <= tag_p.arith;
        end
    end

    // R5
    no_overflow_unsigned_chk: assert property (@(posedge clk) disable iff (rst)
        (vld_q && acc_arith_q == ARITH_UNSIGNED) |-> (int'(acc_q) <= UMAX_SUM));

    // R5
    no_overflow_signed_chk: assert property (@(posedge clk) disable iff (rst)
        (vld_q && acc_arith_q == ARITH_SIGNED) |->
            (int'($signed(acc_q)) <= SMAX_SUM && int'($signed(acc_q)) >= SMIN_SUM));

endmodule

// File: rtl/conv3_filter.sv
module conv3_filter
    import conv3_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      frame_start,
    input  logic                      mode_1d,
    input  logic                      signed_mode,
    input  logic                      in_valid,
    input  logic [PIX_W-1:0]          row0_px,
    input  logic [PIX_W-1:0]          row1_px,
    input  logic [PIX_W-1:0]          row2_px,
    input  logic [TAPS*COEF_W-1:0]    coef_bus,
    output logic [ACC_W-1:0]          out_data,
    output logic                      out_valid
);

    pix_t  [ROWS-1:0] rows;
    coef_t [TAPS-1:0] coefs;
    pix_t  [TAPS-1:0] win;
    stage_tag_t       win_tag;

    assign rows  = {row2_px, row1_px, row0_px};
    assign coefs = coef_bus;

    conv3_window u_window (
        .clk       (clk),
        .rst       (rst),
        .frame_clr (frame_start),
        .in_valid  (in_valid),
        .shape     (shape_e'(mode_1d)),
        .arith_in  (arith_e'(signed_mode)),
        .rows_in   (rows),
        .win_q     (win),
        .tag_q     (win_tag)
    );

    conv3_mac u_mac (
        .clk       (clk),
        .rst       (rst),
        .frame_clr (frame_start),
        .win       (win),
        .coef      (coefs),
        .tag_in    (win_tag),
        .acc_q     (out_data),
        .vld_q     (out_valid)
    );

    // R6
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 3));

    // R8
    frame_kill_chk: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !out_valid);

endmodule

// File: tb/conv3_filter_tb_top.sv
module conv3_filter_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        frame_start, mode_1d, signed_mode, in_valid;
    logic [7:0]  row0_px, row1_px, row2_px;
    logic [71:0] coef_bus;
    logic [19:0] out_data;
    logic        out_valid;

    always #4 clk = ~clk;   // 125 MHz

    conv3_filter dut_i (
        .clk(clk), .rst(rst), .frame_start(frame_start), .mode_1d(mode_1d),
        .signed_mode(signed_mode), .in_valid(in_valid), .row0_px(row0_px),
        .row1_px(row1_px), .row2_px(row2_px), .coef_bus(coef_bus),
        .out_data(out_data), .out_valid(out_valid)
    );

    int    checks = 0;
    int    fails  = 0;
    int    seed   = 7;
    string cur_req = "R1";
    string vld_req = "R6";

    // reference model state
    int mw[9];
    int m_sg = 0;
    int pv[3];
    int pd[3];
    int cf[9];

    function automatic int rnd8();
        seed = seed * 1103515245 + 12345;
        return (seed >>> 16) & 255;
    endfunction

    function automatic int interp(int v, int sg);
        return (sg != 0 && v >= 128) ? v - 256 : v;
    endfunction

    function automatic int model_sum();
        int s = 0;
        for (int k = 0; k < 9; k++)
            s += interp(mw[k], m_sg) * interp(cf[k], m_sg);
        return s;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load_coefs();
        for (int k = 0; k < 9; k++) coef_bus[8*k +: 8] = cf[k][7:0];
    endtask

    // one clock: drive at negedge, model the edge, compare after it
    task automatic step(bit fr, bit iv, int r0, int r1, int r2);
        frame_start = fr; in_valid = iv;
        row0_px = r0[7:0]; row1_px = r1[7:0]; row2_px = r2[7:0];
        @(posedge clk);
        if (fr) begin
            for (int k = 0; k < 9; k++) mw[k] = 0;
            for (int k = 0; k < 3; k++) begin pv[k] = 0; pd[k] = 0; end
        end else begin
            pv[2] = pv[1]; pd[2] = pd[1];
            pv[1] = pv[0]; pd[1] = pd[0];
            if (iv) begin
                if (mode_1d) begin
                    for (int k = 0; k < 8; k++) mw[k] = mw[k+1];
                    mw[8] = r0 & 255;
                end else begin
                    mw[0] = mw[1]; mw[1] = mw[2]; mw[2] = r0 & 255;
                    mw[3] = mw[4]; mw[4] = mw[5]; mw[5] = r1 & 255;
                    mw[6] = mw[7]; mw[7] = mw[8]; mw[8] = r2 & 255;
                end
                m_sg = signed_mode;
            end
            pv[0] = iv;
            pd[0] = model_sum();
        end
        #2;
        check(out_valid === pv[2][0], vld_req, int'(out_valid), pv[2]);
        if (pv[2] != 0)
            check(int'(out_data) == (pd[2] & 32'hFFFFF), cur_req, int'(out_data), pd[2] & 32'hFFFFF);
        @(negedge clk);
    endtask

    task automatic flush();
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 0, 0, 0);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; frame_start = 0; mode_1d = 0; signed_mode = 0; in_valid = 0;
        row0_px = 0; row1_px = 0; row2_px = 0; coef_bus = '0;
        for (int k = 0; k < 9; k++) begin mw[k] = 0; cf[k] = 0; end
        for (int k = 0; k < 3; k++) begin pv[k] = 0; pd[k] = 0; end
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        check(out_valid === 1'b0, "R9", int'(out_valid), 0);
        check(out_data === 20'd0, "R9", int'(out_data), 0);
        rst = 1'b0;
        step(1'b0, 1'b0, 0, 0, 0);
        check(out_valid === 1'b0 && out_data === 20'd0, "R9", int'(out_data), 0);

        // R1 / R2: distinct unsigned weights, 2-D window mapping
        cur_req = "R2"; mode_1d = 0; signed_mode = 0;
        for (int k = 0; k < 9; k++) cf[k] = k + 1;
        load_coefs();
        step(1'b1, 1'b0, 0, 0, 0);
        for (int i = 0; i < 14; i++) step(1'b0, 1'b1, rnd8(), rnd8(), rnd8());
        cur_req = "R1";
        for (int k = 0; k < 9; k++) cf[k] = (k == 4) ? 1 : 0;   // single-centre kernel
        flush(); load_coefs();
        step(1'b1, 1'b0, 0, 0, 0);
        for (int i = 0; i < 8; i++) step(1'b0, 1'b1, rnd8(), rnd8(), rnd8());
        flush();

        // R4: two's complement, random kernel, 2-D
        cur_req = "R4"; signed_mode = 1;
        for (int k = 0; k < 9; k++) cf[k] = rnd8();
        load_coefs();
        step(1'b1, 1'b0, 0, 0, 0);
        for (int i = 0; i < 20; i++) step(1'b0, 1'b1, rnd8(), rnd8(), rnd8());
        flush();

        // R3: 1-D FIR, upper row buses carry noise
        cur_req = "R3"; mode_1d = 1;
        step(1'b1, 1'b0, 0, 0, 0);
        for (int i = 0; i < 20; i++) step(1'b0, 1'b1, rnd8(), rnd8(), rnd8());
        signed_mode = 0;
        for (int i = 0; i < 12; i++) step(1'b0, 1'b1, rnd8(), rnd8(), rnd8());
        flush();

        // R7: idle cycles inside the stream, 2-D unsigned
        cur_req = "R7"; vld_req = "R7"; mode_1d = 0;
        step(1'b1, 1'b0, 0, 0, 0);
        for (int i = 0; i < 24; i++) step(1'b0, rnd8() > 100, rnd8(), rnd8(), rnd8());
        flush();

        // R8: frame pulse mid-stream, also together with in_valid
        cur_req = "R8"; vld_req = "R8";
        step(1'b1, 1'b0, 0, 0, 0);
        for (int i = 0; i < 6; i++) step(1'b0, 1'b1, rnd8(), rnd8(), rnd8());
        step(1'b1, 1'b1, 200, 200, 200);
        for (int i = 0; i < 6; i++) step(1'b0, 1'b1, rnd8(), rnd8(), rnd8());
        mode_1d = 1;
        step(1'b1, 1'b1, 9, 9, 9);
        for (int i = 0; i < 5; i++) step(1'b0, 1'b1, rnd8(), 0, 0);
        flush();

        // R5: extreme operands
        cur_req = "R5"; vld_req = "R6"; mode_1d = 0; signed_mode = 0;
        for (int k = 0; k < 9; k++) cf[k] = 255;
        load_coefs();
        step(1'b1, 1'b0, 0, 0, 0);
        for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 255, 255, 255);   // 585225
        flush();
        signed_mode = 1;
        for (int k = 0; k < 9; k++) cf[k] = 128;
        load_coefs();
        step(1'b1, 1'b0, 0, 0, 0);
        for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 128, 128, 128);   // 147456
        flush();
        for (int k = 0; k < 9; k++) cf[k] = 127;
        load_coefs();
        step(1'b1, 1'b0, 0, 0, 0);
        for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 128, 128, 128);   // -146304
        flush();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule